// File: doc/BRIEF.md
# Pipelined Bus Cycle Sequencer

This block sequences the clocks of an external processor-style bus on which a new address may be issued before the current transfer has finished. Each rising clock edge samples four things: an internal pending-request flag, an active-low ready from the addressed device, an active-low early-address request from that device, and a hold request from an external bus master. The block then moves among seven bus states and reports which one is current.

When the device asks for the next address early and a request is already waiting, the sequencer issues that address at once. It does this in a continuation state that overlaps the end of the running transfer. When ready arrives, the machine goes straight to the first clock of the overlapped cycle and skips the idle clock. A hold request is honoured only at a cycle boundary, and there it wins over a waiting request. While the external master owns the bus, the block holds a hold-acknowledge output high.

The address strobe and the acknowledge to the requester are one-clock pulses. They mark the clock in which the pending request is taken.

Top module: `pipe_bus_seq`

## Requirements
- R1: A synchronous active-high reset places the machine in idle (code 0) with strobe, request acknowledge and hold acknowledge all low. The state codes are: idle=0, hold=1, first-normal=2, continue=3, continue-early-idle=4, continue-early-pending=5, first-pipelined=6.
- R2: In idle or hold, an asserted hold request leads to hold, and it takes priority over a pending request. With hold negated, a pending request leads to first-normal and no request leads to idle.
- R3: First-normal is always followed by continue, whatever the inputs.
- R4: In continue with ready low: hold asserted leads to hold; otherwise a pending request leads to first-normal and no request leads to idle.
- R5: In continue with ready high: early-address low leads to continue-early-pending if hold is negated and a request is pending, and to continue-early-idle otherwise. Early-address high keeps the machine in continue.
- R6: In continue-early-idle with ready low, the exits are those of R4. With ready high, a pending request with hold negated leads to continue-early-pending; otherwise the machine stays in continue-early-idle.
- R7: Continue-early-pending holds while ready is high, and leads to first-pipelined when ready is low.
- R8: First-pipelined leads to continue when early-address is high. When early-address is low, it leads to continue-early-pending if a request is pending and hold is negated, and to continue-early-idle otherwise.
- R9: Hold acknowledge is high in exactly the clocks spent in the hold state.
- R10: Strobe and request acknowledge are equal. Each is high for one clock in first-normal and in the first clock of a stay in continue-early-pending, and low in every other clock.
- R11: The early-address input has no effect in idle, hold, first-normal and continue-early-pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pend_i | input | 1 | Internal request waiting for a bus cycle |
| rdy_n_i | input | 1 | Active-low transfer-complete from the device |
| nxa_n_i | input | 1 | Active-low early-address request from the device |
| hold_i | input | 1 | Bus-ownership request from an external master |
| state_o | output | 3 | Current bus state code (see R1) |
| hold_ack_o | output | 1 | High while the bus is granted away |
| strobe_o | output | 1 | Address strobe pulse |
| req_ack_o | output | 1 | Acknowledge to the requester that its request was taken |

## Verification
Two functions can land on the same edge. One is the end of a transfer, when ready goes low. The other is the arbitration between a waiting request and a hold request. The bench provokes this by presenting ready low together with both request and hold, in continue and in continue-early-idle, and expects hold to win with no strobe. It also does the reverse: it raises a request in the clock where early-address is sampled, and expects the overlapped address strobe at once, then first-pipelined when ready falls.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        BS_IDLE   = 3'd0,
        BS_HOLD   = 3'd1,
        BS_FIRST  = 3'd2,
        BS_CONT   = 3'd3,
        BS_CONT_E = 3'd4,
        BS_CONT_P = 3'd5,
        BS_FIRSTP = 3'd6
    } bus_state_e;

    typedef struct packed {
        logic req;
        logic done;
        logic early;
        logic hold;
    } bus_in_t;

    typedef struct packed {
        logic hold_ack;
        logic strobe;
        logic req_ack;
    } bus_out_t;

    // Exit taken at a cycle boundary: hold first, then a waiting request.
    function automatic bus_state_e boundary_exit(input bus_in_t b);
        if (b.hold)
            return BS_HOLD;
        else if (b.req)
            return BS_FIRST;
        else
            return BS_IDLE;
    endfunction

    // Early address granted: overlap only with a request and no hold.
    function automatic bus_state_e early_exit(input bus_in_t b);
        if (b.req && !b.hold)
            return BS_CONT_P;
        else
            return BS_CONT_E;
    endfunction

endpackage

// File: rtl/pbs_next.sv
module pbs_next
    import pbs_pkg::*;
(
    input  bus_state_e cur_i,
    input  bus_in_t    in_i,
    output bus_state_e nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            BS_IDLE, BS_HOLD: nxt_o = boundary_exit(in_i);
            BS_FIRST:         nxt_o = BS_CONT;
            BS_CONT: begin
                if (in_i.done)
                    nxt_o = boundary_exit(in_i);
                else if (in_i.early)
                    nxt_o = early_exit(in_i);
                else
                    nxt_o = BS_CONT;
            end
            BS_CONT_E: begin
                if (in_i.done)
                    nxt_o = boundary_exit(in_i);
                else if (in_i.req && !in_i.hold)
                    nxt_o = BS_CONT_P;
                else
                    nxt_o = BS_CONT_E;
            end
            BS_CONT_P: nxt_o = in_i.done ? BS_FIRSTP : BS_CONT_P;
            BS_FIRSTP: nxt_o = in_i.early ? early_exit(in_i) : BS_CONT;
            default:   nxt_o = BS_IDLE;
        endcase
    end
endmodule

// File: rtl/pbs_state_reg.sv
module pbs_state_reg
    import pbs_pkg::*;
#(
    parameter bus_state_e RESET_STATE = BS_IDLE
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_state_e nxt_i,
    output bus_state_e cur_o,
    output bus_state_e prev_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_o  <= RESET_STATE;
            prev_o <= RESET_STATE;
        end else begin
            cur_o  <= nxt_i;
            prev_o <= cur_o;
        end
    end
endmodule

// File: rtl/pbs_outdec.sv
module pbs_outdec
    import pbs_pkg::*;
(
    input  bus_state_e cur_i,
    input  bus_state_e prev_i,
    output bus_out_t   out_o
);
    logic enter_pipe;

    always_comb begin
        enter_pipe     = (cur_i == BS_CONT_P) && (prev_i != BS_CONT_P);
        out_o.hold_ack = (cur_i == BS_HOLD);
        out_o.strobe   = (cur_i == BS_FIRST) || enter_pipe;
        out_o.req_ack  = (cur_i == BS_FIRST) || enter_pipe;
    end
endmodule

// File: rtl/pipe_bus_seq.sv
module pipe_bus_seq
    import pbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_pend_i,
    input  logic               rdy_n_i,
    input  logic               nxa_n_i,
    input  logic               hold_i,
    output logic [STATE_W-1:0] state_o,
    output logic               hold_ack_o,
    output logic               strobe_o,
    output logic               req_ack_o
);
    bus_in_t    bin;
    bus_out_t   bout;
    bus_state_e cur_st, prev_st, nxt_st;

    always_comb begin
        bin.req   = req_pend_i;
        bin.done  = ~rdy_n_i;
        bin.early = ~nxa_n_i;
        bin.hold  = hold_i;
    end

    pbs_next u_next (
        .cur_i (cur_st),
        .in_i  (bin),
        .nxt_o (nxt_st)
    );

    pbs_state_reg #(.RESET_STATE(BS_IDLE)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .nxt_i  (nxt_st),
        .cur_o  (cur_st),
        .prev_o (prev_st)
    );

    pbs_outdec u_dec (
        .cur_i  (cur_st),
        .prev_i (prev_st),
        .out_o  (bout)
    );

    assign state_o    = cur_st;
    assign hold_ack_o = bout.hold_ack;
    assign strobe_o   = bout.strobe;
    assign req_ack_o  = bout.req_ack;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_pend_i,
    input logic       rdy_n_i,
    input logic       nxa_n_i,
    input logic       hold_i,
    input logic [2:0] state_o,
    input logic       hold_ack_o,
    input logic       strobe_o,
    input logic       req_ack_o
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (state_o == 3'd0 && !strobe_o && !hold_ack_o));

    assert_hold_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0 && hold_i) |=> state_o == 3'd1);

    assert_first_to_cont_R3: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd2 |=> state_o == 3'd3);

    assert_pipe_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd5 && rdy_n_i) |=> state_o == 3'd5);

    assert_firstp_plain_R8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd6 && nxa_n_i) |=> state_o == 3'd3);

    assert_hack_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_o) |-> $past(hold_i));

    assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o);

    assert_ack_matches_R10: assert property (@(posedge clk) disable iff (rst)
        strobe_o == req_ack_o);
endmodule

bind pipe_bus_seq pbs_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_pend_i (req_pend_i),
    .rdy_n_i    (rdy_n_i),
    .nxa_n_i    (nxa_n_i),
    .hold_i     (hold_i),
    .state_o    (state_o),
    .hold_ack_o (hold_ack_o),
    .strobe_o   (strobe_o),
    .req_ack_o  (req_ack_o)
);

// File: tb/pipe_bus_seq_tb.sv
module pipe_bus_seq_tb;
    localparam logic [2:0] S_I = 3'd0, S_H = 3'd1, S_1 = 3'd2, S_2 = 3'd3,
                           S_2I = 3'd4, S_2P = 3'd5, S_1P = 3'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, rdy_n = 1'b1, nxa_n = 1'b1, hold = 1'b0;
    logic [2:0] state;
    logic hack, stb, ack;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pipe_bus_seq u_dut (
        .clk(clk), .rst(rst), .req_pend_i(req), .rdy_n_i(rdy_n),
        .nxa_n_i(nxa_n), .hold_i(hold), .state_o(state),
        .hold_ack_o(hack), .strobe_o(stb), .req_ack_o(ack)
    );

    task automatic expect_out(input string tag, input logic [2:0] es,
                              input logic estb, input logic ehk);
        n_chk++;
        if (state !== es || stb !== estb || ack !== estb || hack !== ehk) begin
            n_bad++;
            $display("FAIL %s: state=%0d strobe=%b ack=%b hack=%b expected state=%0d strobe=%b ack=%b hack=%b",
                     tag, state, stb, ack, hack, es, estb, estb, ehk);
        end
    endtask

    // Drive inputs away from the edge, let one edge pass, check after it.
    task automatic step(input logic r, input logic rn, input logic nn,
                        input logic h, input string tag, input logic [2:0] es,
                        input logic estb, input logic ehk);
        @(negedge clk);
        req = r; rdy_n = rn; nxa_n = nn; hold = h;
        @(posedge clk);
        #1;
        expect_out(tag, es, estb, ehk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(negedge clk); req = 1'b1; hold = 1'b1; nxa_n = 1'b0; rdy_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        expect_out("R1 reset state", S_I, 1'b0, 1'b0);
        @(negedge clk); rst = 1'b0; req = 0; hold = 0; nxa_n = 1; rdy_n = 1;
    endtask

    task automatic t_basic;
        step(1, 1, 1, 0, "R2 idle req", S_1, 1, 0);
        step(0, 1, 1, 0, "R3 first->cont", S_2, 0, 0);
        step(0, 1, 1, 0, "R5 cont wait", S_2, 0, 0);
        step(0, 0, 1, 0, "R4 cont done idle", S_I, 0, 0);
    endtask

    task automatic t_back2back;
        step(1, 1, 1, 0, "R10 strobe first", S_1, 1, 0);
        step(0, 1, 1, 0, "R3 cont", S_2, 0, 0);
        step(1, 0, 1, 0, "R4 cont done req", S_1, 1, 0);
        step(0, 1, 1, 0, "R3 cont again", S_2, 0, 0);
        step(1, 0, 1, 1, "R4 done hold wins", S_H, 0, 1);
        step(1, 1, 0, 1, "R9 hold kept", S_H, 0, 1);
        step(1, 1, 1, 0, "R2 hold release req", S_1, 1, 0);
        step(0, 1, 1, 0, "R3 cont", S_2, 0, 0);
        step(0, 0, 1, 0, "R4 idle", S_I, 0, 0);
    endtask

    task automatic t_hold_idle;
        step(1, 1, 1, 1, "R2 hold priority", S_H, 0, 1);
        step(0, 1, 1, 0, "R2 hold release idle", S_I, 0, 0);
    endtask

    task automatic t_pipe;
        step(1, 1, 1, 0, "R2 start", S_1, 1, 0);
        step(0, 1, 1, 0, "R3 cont", S_2, 0, 0);
        step(1, 1, 0, 0, "R5 early pending", S_2P, 1, 0);
        step(0, 1, 0, 0, "R7 pipe wait no strobe", S_2P, 0, 0);
        step(0, 0, 1, 0, "R7 to first pipelined", S_1P, 0, 0);
        step(0, 1, 1, 0, "R8 firstp plain", S_2, 0, 0);
        step(0, 0, 1, 0, "R4 idle", S_I, 0, 0);
    endtask

    task automatic t_early_idle;
        step(1, 1, 1, 0, "R2 start", S_1, 1, 0);
        step(0, 1, 1, 0, "R3 cont", S_2, 0, 0);
        step(0, 1, 0, 0, "R5 early no req", S_2I, 0, 0);
        step(1, 1, 1, 1, "R6 hold blocks overlap", S_2I, 0, 0);
        step(1, 1, 1, 0, "R6 late req overlap", S_2P, 1, 0);
        step(0, 0, 1, 0, "R7 firstp", S_1P, 0, 0);
        step(1, 1, 0, 0, "R8 firstp early req", S_2P, 1, 0);
        step(0, 0, 1, 0, "R7 firstp again", S_1P, 0, 0);
        step(0, 1, 0, 0, "R8 firstp early idle", S_2I, 0, 0);
        step(1, 0, 1, 1, "R6 done hold wins", S_H, 0, 1);
        step(0, 1, 1, 0, "R2 release", S_I, 0, 0);
        step(1, 1, 1, 0, "R2 start", S_1, 1, 0);
        step(0, 1, 1, 0, "R3 cont", S_2, 0, 0);
        step(1, 1, 0, 1, "R5 early with hold", S_2I, 0, 0);
        step(1, 0, 1, 0, "R6 done req", S_1, 1, 0);
        step(0, 1, 1, 0, "R3 cont", S_2, 0, 0);
        step(0, 1, 0, 0, "R5 early no req", S_2I, 0, 0);
        step(0, 0, 1, 0, "R6 done idle", S_I, 0, 0);
    endtask

    task automatic t_ignore;
        step(0, 1, 0, 0, "R11 idle early ignored", S_I, 0, 0);
        step(0, 0, 0, 1, "R11 hold entry", S_H, 0, 1);
        step(0, 0, 0, 1, "R11 hold early ignored", S_H, 0, 1);
        step(1, 0, 0, 0, "R11 start", S_1, 1, 0);
        step(0, 0, 0, 0, "R11 first ignores early", S_2, 0, 0);
        step(1, 1, 0, 0, "R5 early pending", S_2P, 1, 0);
        step(0, 1, 0, 1, "R11 pending ignores early", S_2P, 0, 0);
        step(0, 0, 1, 0, "R7 firstp", S_1P, 0, 0);
        step(0, 1, 1, 0, "R8 cont", S_2, 0, 0);
        step(0, 0, 1, 0, "R4 idle", S_I, 0, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_back2back();
        t_hold_idle();
        t_pipe();
        t_early_idle();
        t_ignore();
        t_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule